// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the control logic that steers a small 32-bit processor into and out of exception and interrupt handlers. Each clock cycle it looks at the instruction that is completing and at any pending requests: an exception of a given class, an interrupt at a given priority level, a return-from-exception strobe and a status-register load. From these it picks exactly one action and updates the architectural control state. That state is the status word, the saved status, the saved return PC, the vector base and the event code. Whenever the program counter must change, it also drives a new fetch address together with a one-cycle redirect pulse.

The saved return address depends on the exception class, on whether the instruction sits in a branch delay slot, and on the outcome of a conditional delayed branch. A block bit in the status word holds interrupts pending, except in low-power mode. While that bit is set, an exception does not enter its handler; it escalates to the reset vector. The same bit also tells the debug logic to suppress user-break traps.

Top module: `exc_seq_top`

## Requirements
- R1: Synchronous reset, active high, sets the fetch PC to 0xA0000000, VBR to 0, and the status word to 0x700000F0: mode (bit 30), bank (bit 29) and block (bit 28) are set, the interrupt mask (bits 7:4) is 0xF, and all other bits are 0. SSR, SPC and EXPEVT reset to 0, and redirect is low.
- R2: A re-executing exception (class 0) saves the faulting instruction's PC in SPC. If the fault is in a delay slot, it saves the PC of the delayed branch in front of it instead.
- R3: A completed exception (class 1) or an accepted interrupt saves the PC of the next instruction (current PC + 2) in SPC. If the completing instruction is a taken conditional delayed branch, it saves the branch target instead.
- R4: When the conditional delayed branch involved was not taken, SPC receives the delay-slot PC. For a re-executing fault inside the slot, that is the current PC. For a completed event on the branch itself, it is the current PC + 2.
- R5: On entry, SSR takes the old status word; the mode, bank and block bits are set and the other status bits are kept. EXPEVT takes the request's code. The PC becomes VBR + 0x100 for an exception or VBR + 0x600 for an interrupt, and redirect is high for that one cycle.
- R6: An interrupt is accepted only when its level is strictly greater than the mask and the block bit is 0. Otherwise it stays pending while the request is held. A held request is taken in the cycle after the instruction (RTE or status load) that clears the block bit.
- R7: While the sleep input is high, an interrupt whose level exceeds the mask is accepted even with the block bit set.
- R8: An exception raised while the block bit is 1 redirects to 0xA0000000. It sets mode, bank and block, and sets the mask to 0xF. SPC, SSR and EXPEVT are left unchanged.
- R9: The user-break suppress output equals the block bit of the status word at all times.
- R10: RTE loads the PC from SPC and the status word from SSR, with a redirect pulse.
- R11: Per-cycle priority is reset, then exception, then RTE or status load, then interrupt. A VBR write takes effect after any entry in the same cycle, and a status load never redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | PC of the completing or faulting instruction |
| in_dslot | input | 1 | That instruction sits in a delay slot |
| slot_branch_pc | input | 32 | PC of the delayed branch owning the slot |
| branch_target | input | 32 | Target of the conditional delayed branch |
| cond_branch | input | 1 | A conditional delayed branch is involved |
| cond_taken | input | 1 | Its condition was met |
| exc_req | input | 1 | Exception request |
| exc_class | input | 1 | 0 re-executing, 1 completed |
| exc_code | input | 12 | Event code for the exception |
| irq_req | input | 1 | Interrupt request |
| irq_level | input | 4 | Interrupt priority level |
| irq_code | input | 12 | Event code for the interrupt |
| sleeping | input | 1 | Sleep or standby mode active |
| rte | input | 1 | Return-from-exception strobe |
| sr_load | input | 1 | Status-word load strobe |
| sr_din | input | 32 | Status-word load value |
| vbr_wr | input | 1 | Vector base write strobe |
| vbr_din | input | 32 | Vector base write value |
| pc_out | output | 32 | Fetch PC after the last redirect |
| redirect | output | 1 | One-cycle pulse: fetch from pc_out |
| sr_out | output | 32 | Status word |
| ssr_out | output | 32 | Saved status word |
| spc_out | output | 32 | Saved return PC |
| vbr_out | output | 32 | Vector base |
| expevt_out | output | 12 | Event code of the last entry |
| ubrk_suppress | output | 1 | Suppress user-break traps |

## Verification
The hardest situation to reach from the ports is a held interrupt that is refused while the block bit is set and then accepted in the very next cycle after an RTE clears that bit. The stimulus first enters an interrupt handler, which sets the block bit. It keeps the higher-level request asserted through idle cycles that must show no redirect, then issues RTE with the request still held. The bench expects the RTE redirect first and the interrupt vector one cycle later. Escalation and the sleep override are reached in a similar way: the block bit is left set, either after reset or inside a handler, and an exception or a sleeping interrupt is presented.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  // status word field positions
  localparam int SR_MD    = 30;
  localparam int SR_RB    = 29;
  localparam int SR_BL    = 28;
  localparam int SR_IM_LO = 4;
  localparam int IM_W     = 4;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_RESET,
    ACT_EXC,
    ACT_ESCALATE,
    ACT_RTE,
    ACT_SRLOAD,
    ACT_IRQ
  } act_e;

  typedef enum logic {
    CLS_REEXEC   = 1'b0,
    CLS_COMPLETE = 1'b1
  } exc_cls_e;
endpackage

// File: rtl/exc_ret_sel.sv
// Chooses the return PC saved in SPC on entry.
module exc_ret_sel #(
  parameter int XLEN        = 32,
  parameter int INSTR_BYTES = 2
) (
  input  logic            use_completed,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            in_dslot,
  input  logic [XLEN-1:0] slot_branch_pc,
  input  logic [XLEN-1:0] branch_target,
  input  logic            cond_branch,
  input  logic            cond_taken,
  output logic [XLEN-1:0] ret_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic [XLEN-1:0] seq_pc;
  logic            not_taken;

  assign seq_pc    = cur_pc + STEP;
  assign not_taken = cond_branch & ~cond_taken;

  always_comb begin
    if (!use_completed) begin
      // fault re-executes; inside a slot the owning branch is replayed
      // unless that branch fell through, in which case the slot itself is
      if (in_dslot && !not_taken) ret_pc = slot_branch_pc;
      else                        ret_pc = cur_pc;
    end else begin
      if (cond_branch && cond_taken) ret_pc = branch_target;
      else                           ret_pc = seq_pc;
    end
  end
endmodule

// File: rtl/exc_arbiter.sv
// Picks one action per cycle.
module exc_arbiter
  import exc_seq_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             rst,
  input  logic             exc_req,
  input  logic             rte,
  input  logic             sr_load,
  input  logic             irq_req,
  input  logic [LVL_W-1:0] irq_level,
  input  logic [IM_W-1:0]  sr_mask,
  input  logic             sr_bl,
  input  logic             sleeping,
  output act_e             act
);
  logic irq_ok;

  assign irq_ok = irq_req && (LVL_W'(irq_level) > LVL_W'(sr_mask)) && (!sr_bl || sleeping);

  always_comb begin
    if (rst)          act = ACT_RESET;
    else if (exc_req) act = sr_bl ? ACT_ESCALATE : ACT_EXC;
    else if (rte)     act = ACT_RTE;
    else if (sr_load) act = ACT_SRLOAD;
    else if (irq_ok)  act = ACT_IRQ;
    else              act = ACT_IDLE;
  end
endmodule

// File: rtl/exc_state.sv
// Architectural control registers and their next-state logic.
module exc_state
  import exc_seq_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              CODE_W    = 12,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000,
  parameter logic [XLEN-1:0] VBR_INIT  = '0,
  parameter logic [XLEN-1:0] EXC_OFS   = 32'h100,
  parameter logic [XLEN-1:0] IRQ_OFS   = 32'h600
) (
  input  logic              clk,
  input  act_e              act,
  input  logic [XLEN-1:0]   ret_pc,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [XLEN-1:0]   sr_din,
  input  logic              vbr_wr,
  input  logic [XLEN-1:0]   vbr_din,
  output logic [XLEN-1:0]   pc_q,
  output logic              redirect_q,
  output logic [XLEN-1:0]   sr_q,
  output logic [XLEN-1:0]   ssr_q,
  output logic [XLEN-1:0]   spc_q,
  output logic [XLEN-1:0]   vbr_q,
  output logic [CODE_W-1:0] expevt_q,
  output logic              ubrk_q
);
  localparam logic [XLEN-1:0] CTL_BITS = (XLEN'(1) << SR_MD) | (XLEN'(1) << SR_RB) |
                                         (XLEN'(1) << SR_BL);
  localparam logic [XLEN-1:0] MASK_ALL = XLEN'({IM_W{1'b1}}) << SR_IM_LO;
  localparam logic [XLEN-1:0] SR_RESET = CTL_BITS | MASK_ALL;

  logic [XLEN-1:0]   pc_n, sr_n, ssr_n, spc_n, vbr_n;
  logic [CODE_W-1:0] expevt_n;
  logic              redirect_n;

  always_comb begin
    pc_n       = pc_q;
    sr_n       = sr_q;
    ssr_n      = ssr_q;
    spc_n      = spc_q;
    vbr_n      = vbr_q;
    expevt_n   = expevt_q;
    redirect_n = 1'b0;
    unique case (act)
      ACT_RESET: begin
        pc_n     = RESET_VEC;
        sr_n     = SR_RESET;
        ssr_n    = '0;
        spc_n    = '0;
        vbr_n    = VBR_INIT;
        expevt_n = '0;
      end
      ACT_EXC, ACT_IRQ: begin
        ssr_n      = sr_q;
        spc_n      = ret_pc;
        sr_n       = sr_q | CTL_BITS;
        expevt_n   = (act == ACT_EXC) ? exc_code : irq_code;
        pc_n       = vbr_q + ((act == ACT_EXC) ? EXC_OFS : IRQ_OFS);
        redirect_n = 1'b1;
      end
      ACT_ESCALATE: begin
        pc_n       = RESET_VEC;
        sr_n       = sr_q | CTL_BITS | MASK_ALL;
        redirect_n = 1'b1;
      end
      ACT_RTE: begin
        pc_n       = spc_q;
        sr_n       = ssr_q;
        redirect_n = 1'b1;
      end
      ACT_SRLOAD: sr_n = sr_din;
      default: ;
    endcase
    // base write lands after any entry that used the old base
    if (vbr_wr && act != ACT_RESET) vbr_n = vbr_din;
  end

  always_ff @(posedge clk) begin
    pc_q       <= pc_n;
    sr_q       <= sr_n;
    ssr_q      <= ssr_n;
    spc_q      <= spc_n;
    vbr_q      <= vbr_n;
    expevt_q   <= expevt_n;
    redirect_q <= redirect_n;
    ubrk_q     <= sr_n[SR_BL];
  end
endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
  import exc_seq_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              CODE_W      = 12,
  parameter int              LVL_W       = 4,
  parameter int              INSTR_BYTES = 2,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'hA000_0000,
  parameter logic [XLEN-1:0] VBR_INIT    = '0,
  parameter logic [XLEN-1:0] EXC_OFS     = 32'h100,
  parameter logic [XLEN-1:0] IRQ_OFS     = 32'h600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              in_dslot,
  input  logic [XLEN-1:0]   slot_branch_pc,
  input  logic [XLEN-1:0]   branch_target,
  input  logic              cond_branch,
  input  logic              cond_taken,
  input  logic              exc_req,
  input  logic              exc_class,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [CODE_W-1:0] irq_code,
  input  logic              sleeping,
  input  logic              rte,
  input  logic              sr_load,
  input  logic [XLEN-1:0]   sr_din,
  input  logic              vbr_wr,
  input  logic [XLEN-1:0]   vbr_din,
  output logic [XLEN-1:0]   pc_out,
  output logic              redirect,
  output logic [XLEN-1:0]   sr_out,
  output logic [XLEN-1:0]   ssr_out,
  output logic [XLEN-1:0]   spc_out,
  output logic [XLEN-1:0]   vbr_out,
  output logic [CODE_W-1:0] expevt_out,
  output logic              ubrk_suppress
);
  act_e            act;
  logic [XLEN-1:0] ret_pc;
  logic            use_completed;

  // interrupts always use the completed-class rule
  assign use_completed = !exc_req || (exc_class == CLS_COMPLETE);

  exc_arbiter #(.LVL_W(LVL_W)) u_arb (
    .rst       (rst),
    .exc_req   (exc_req),
    .rte       (rte),
    .sr_load   (sr_load),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .sr_mask   (sr_out[SR_IM_LO +: IM_W]),
    .sr_bl     (sr_out[SR_BL]),
    .sleeping  (sleeping),
    .act       (act)
  );

  exc_ret_sel #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) u_ret (
    .use_completed  (use_completed),
    .cur_pc         (cur_pc),
    .in_dslot       (in_dslot),
    .slot_branch_pc (slot_branch_pc),
    .branch_target  (branch_target),
    .cond_branch    (cond_branch),
    .cond_taken     (cond_taken),
    .ret_pc         (ret_pc)
  );

  exc_state #(
    .XLEN(XLEN), .CODE_W(CODE_W), .RESET_VEC(RESET_VEC),
    .VBR_INIT(VBR_INIT), .EXC_OFS(EXC_OFS), .IRQ_OFS(IRQ_OFS)
  ) u_state (
    .clk        (clk),
    .act        (act),
    .ret_pc     (ret_pc),
    .exc_code   (exc_code),
    .irq_code   (irq_code),
    .sr_din     (sr_din),
    .vbr_wr     (vbr_wr),
    .vbr_din    (vbr_din),
    .pc_q       (pc_out),
    .redirect_q (redirect),
    .sr_q       (sr_out),
    .ssr_q      (ssr_out),
    .spc_q      (spc_out),
    .vbr_q      (vbr_out),
    .expevt_q   (expevt_out),
    .ubrk_q     (ubrk_suppress)
  );
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
  import exc_seq_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              CODE_W    = 12,
  parameter int              LVL_W     = 4,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000,
  parameter logic [XLEN-1:0] EXC_OFS   = 32'h100,
  parameter logic [XLEN-1:0] IRQ_OFS   = 32'h600
) (
  input logic              clk,
  input logic              rst,
  input logic              exc_req,
  input logic              irq_req,
  input logic [LVL_W-1:0]  irq_level,
  input logic              sleeping,
  input logic              rte,
  input logic              sr_load,
  input logic [XLEN-1:0]   pc_out,
  input logic              redirect,
  input logic [XLEN-1:0]   sr_out,
  input logic [XLEN-1:0]   ssr_out,
  input logic [XLEN-1:0]   spc_out,
  input logic [XLEN-1:0]   vbr_out,
  input logic [CODE_W-1:0] expevt_out,
  input logic              ubrk_suppress
);
  logic [IM_W-1:0] mask;
  assign mask = sr_out[SR_IM_LO +: IM_W];

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (pc_out == RESET_VEC && !redirect && sr_out[SR_BL] && mask == '1));

  assert_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (exc_req && !sr_out[SR_BL]) |=>
      (redirect && ssr_out == $past(sr_out) && sr_out[SR_BL] && sr_out[SR_MD] &&
       pc_out == $past(vbr_out) + EXC_OFS));

  assert_masked_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !exc_req && !rte && !sr_load && LVL_W'(irq_level) <= LVL_W'(mask)) |=> !redirect);

  assert_sleep_wake_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_req && sleeping && !exc_req && !rte && !sr_load && LVL_W'(irq_level) > LVL_W'(mask)) |=>
      (redirect && pc_out == $past(vbr_out) + IRQ_OFS));

  assert_escalate_R8: assert property (@(posedge clk) disable iff (rst)
    (exc_req && sr_out[SR_BL]) |=>
      (redirect && pc_out == RESET_VEC && $stable(spc_out) && $stable(ssr_out) && $stable(expevt_out)));

  assert_ubrk_R9: assert property (@(posedge clk) disable iff (rst)
    ubrk_suppress == sr_out[SR_BL]);

  assert_rte_R10: assert property (@(posedge clk) disable iff (rst)
    (rte && !exc_req) |=> (redirect && pc_out == $past(spc_out) && sr_out == $past(ssr_out)));
endmodule

bind exc_seq_top exc_seq_chk #(
  .XLEN(XLEN), .CODE_W(CODE_W), .LVL_W(LVL_W), .RESET_VEC(RESET_VEC),
  .EXC_OFS(EXC_OFS), .IRQ_OFS(IRQ_OFS)
) u_chk (
  .clk(clk), .rst(rst), .exc_req(exc_req), .irq_req(irq_req), .irq_level(irq_level),
  .sleeping(sleeping), .rte(rte), .sr_load(sr_load), .pc_out(pc_out), .redirect(redirect),
  .sr_out(sr_out), .ssr_out(ssr_out), .spc_out(spc_out), .vbr_out(vbr_out),
  .expevt_out(expevt_out), .ubrk_suppress(ubrk_suppress)
);

// File: tb/exc_seq_top_tb.sv
module exc_seq_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cur_pc = '0, slot_branch_pc = '0, branch_target = '0, sr_din = '0, vbr_din = '0;
  logic        in_dslot = 0, cond_branch = 0, cond_taken = 0, exc_req = 0, exc_class = 0;
  logic        irq_req = 0, sleeping = 0, rte = 0, sr_load = 0, vbr_wr = 0;
  logic [11:0] exc_code = '0, irq_code = '0;
  logic [3:0]  irq_level = '0;
  logic [31:0] pc_out, sr_out, ssr_out, spc_out, vbr_out;
  logic        redirect, ubrk_suppress;
  logic [11:0] expevt_out;

  always #4 clk = ~clk;  // 125 MHz

  exc_seq_top u_dut (
    .clk(clk), .rst(rst), .cur_pc(cur_pc), .in_dslot(in_dslot), .slot_branch_pc(slot_branch_pc),
    .branch_target(branch_target), .cond_branch(cond_branch), .cond_taken(cond_taken),
    .exc_req(exc_req), .exc_class(exc_class), .exc_code(exc_code), .irq_req(irq_req),
    .irq_level(irq_level), .irq_code(irq_code), .sleeping(sleeping), .rte(rte),
    .sr_load(sr_load), .sr_din(sr_din), .vbr_wr(vbr_wr), .vbr_din(vbr_din),
    .pc_out(pc_out), .redirect(redirect), .sr_out(sr_out), .ssr_out(ssr_out),
    .spc_out(spc_out), .vbr_out(vbr_out), .expevt_out(expevt_out), .ubrk_suppress(ubrk_suppress)
  );

  typedef struct {
    int          due;
    string       tag;
    logic [31:0] pc, sr, ssr, spc, vbr;
    logic        red, ub;
    logic [11:0] ev;
  } item_t;

  item_t q[$];
  int    cyc = 0, checks = 0, errors = 0;
  bit    done = 0;

  // reference model state
  logic [31:0] m_pc, m_sr, m_ssr, m_spc, m_vbr;
  logic [11:0] m_ev;
  logic        m_red;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (pc_out !== e.pc || redirect !== e.red || sr_out !== e.sr || ssr_out !== e.ssr ||
          spc_out !== e.spc || vbr_out !== e.vbr || expevt_out !== e.ev || ubrk_suppress !== e.ub) begin
        errors++;
        $display("FAIL %s: actual pc=%h red=%b sr=%h ssr=%h spc=%h vbr=%h ev=%h ub=%b expected pc=%h red=%b sr=%h ssr=%h spc=%h vbr=%h ev=%h ub=%b",
                 e.tag, pc_out, redirect, sr_out, ssr_out, spc_out, vbr_out, expevt_out, ubrk_suppress,
                 e.pc, e.red, e.sr, e.ssr, e.spc, e.vbr, e.ev, e.ub);
      end
    end
  end

  function automatic logic [31:0] ret_of(input logic completed);
    if (!completed) begin
      if (in_dslot && !(cond_branch && !cond_taken)) return slot_branch_pc;
      return cur_pc;
    end
    if (cond_branch && cond_taken) return branch_target;
    return cur_pc + 32'd2;
  endfunction

  // driver: inputs already set by caller; model one cycle and push expectation
  task automatic apply(input string tag);
    item_t e;
    logic  irq_ok;
    irq_ok = irq_req && (irq_level > m_sr[7:4]) && (!m_sr[28] || sleeping);
    m_red = 0;
    if (rst) begin
      m_pc = 32'hA000_0000; m_sr = 32'h7000_00F0; m_ssr = 0; m_spc = 0; m_vbr = 0; m_ev = 0;
    end else begin
      if (exc_req) begin
        if (m_sr[28]) begin
          m_pc = 32'hA000_0000; m_sr = m_sr | 32'h7000_00F0; m_red = 1;
        end else begin
          m_ssr = m_sr; m_spc = ret_of(exc_class); m_sr = m_sr | 32'h7000_0000;
          m_ev = exc_code; m_pc = m_vbr + 32'h100; m_red = 1;
        end
      end else if (rte) begin
        m_pc = m_spc; m_sr = m_ssr; m_red = 1;
      end else if (sr_load) begin
        m_sr = sr_din;
      end else if (irq_ok) begin
        m_ssr = m_sr; m_spc = ret_of(1'b1); m_sr = m_sr | 32'h7000_0000;
        m_ev = irq_code; m_pc = m_vbr + 32'h600; m_red = 1;
      end
      if (vbr_wr) m_vbr = vbr_din;
    end
    e.due = cyc + 1; e.tag = tag; e.pc = m_pc; e.red = m_red; e.sr = m_sr; e.ssr = m_ssr;
    e.spc = m_spc; e.vbr = m_vbr; e.ev = m_ev; e.ub = m_sr[28];
    q.push_back(e);
    @(negedge clk);
    exc_req = 0; rte = 0; sr_load = 0; vbr_wr = 0; in_dslot = 0; cond_branch = 0; cond_taken = 0;
  endtask

  task automatic exc(input logic cls, input logic [31:0] pc, input logic ds, input logic [31:0] bpc,
                     input logic cb, input logic ct, input logic [31:0] tgt, input string tag);
    exc_req = 1; exc_class = cls; cur_pc = pc; in_dslot = ds; slot_branch_pc = bpc;
    cond_branch = cb; cond_taken = ct; branch_target = tgt; exc_code = exc_code + 12'h020;
    apply(tag);
  endtask

  task automatic do_rte(input string tag); rte = 1; apply(tag); endtask
  task automatic load_sr(input logic [31:0] v, input string tag); sr_load = 1; sr_din = v; apply(tag); endtask

  initial begin
    @(negedge clk);
    rst = 1; apply("R1 reset state"); apply("R1 R9 reset held");
    rst = 0;
    exc(0, 32'h100, 0, 0, 0, 0, 0, "R8 exception with block set after reset");
    load_sr(32'h4000_0000, "R9 status load clears block, no redirect R11");
    vbr_wr = 1; vbr_din = 32'h8000_0000; apply("R11 vbr write");
    exc(0, 32'h1000, 0, 0, 0, 0, 0, "R2 R5 re-exec plain");
    do_rte("R10 return");
    exc(0, 32'h2002, 1, 32'h2000, 0, 0, 0, "R2 re-exec in delay slot");
    do_rte("R10 return");
    exc(0, 32'h2002, 1, 32'h2000, 1, 0, 0, "R4 re-exec slot, branch not taken");
    do_rte("R10 return");
    exc(1, 32'h3000, 0, 0, 0, 0, 0, "R3 completed plain");
    do_rte("R10 return");
    exc(1, 32'h3010, 0, 0, 1, 1, 32'h4000, "R3 completed on taken cond branch");
    do_rte("R10 return");
    exc(1, 32'h3100, 0, 0, 1, 0, 32'h4000, "R4 completed on untaken cond branch");
    do_rte("R10 return");
    // interrupts
    load_sr(32'h4000_0050, "R11 set mask 5");
    irq_req = 1; irq_level = 5; irq_code = 12'h3C0; cur_pc = 32'h5000;
    apply("R6 level equal to mask refused");
    irq_level = 6; apply("R6 R5 interrupt entry");
    irq_level = 9; cur_pc = 32'h6000; apply("R6 held while block set");
    apply("R6 still held");
    do_rte("R6 R10 rte clears block with irq held");
    apply("R6 irq taken right after block cleared");
    irq_req = 0;
    exc(0, 32'h6100, 0, 0, 0, 0, 0, "R8 exception inside handler escalates");
    load_sr(32'h4000_0000, "R11 reopen");
    irq_req = 1; irq_level = 3; cur_pc = 32'h7000;
    exc(1, 32'h7000, 0, 0, 0, 0, 0, "R11 exception beats interrupt");
    do_rte("R11 rte beats interrupt");
    apply("R11 interrupt after rte");
    irq_req = 0;
    load_sr(32'h7000_0030, "R11 block set, mask 3");
    irq_req = 1; irq_level = 4; apply("R7 not sleeping: refused");
    sleeping = 1; cur_pc = 32'h7200; apply("R7 sleeping accepts with block set");
    sleeping = 0; irq_req = 0;
    load_sr(32'h4000_0000, "R11 reopen");
    sr_load = 1; sr_din = 32'h0; exc(0, 32'h7300, 0, 0, 0, 0, 0, "R11 exception beats status load");
    vbr_wr = 1; vbr_din = 32'h9000_0000; do_rte("R11 vbr write with rte");
    apply("idle");
    rst = 1; apply("R1 reset mid-run");
    rst = 0; apply("R1 after reset");
    @(negedge clk); @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule